// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a single-slave SPI master driven through a small register port. Software chooses the word length, the clock polarity, the clock phase and a divider of the system clock. It then loads a transmit word and writes a start command. The controller lowers the active-low select, clocks out the low bits of the transmit word most significant bit first, and shifts in the same number of bits from the slave. At the end it releases the select and raises a done flag. The received word can then be read back.

The register port is a plain read/write interface with a two-bit address. Reads are combinational. Writes take effect on the rising clock edge while `regWrEn` is high. There are four addresses: 0 is configuration, 1 is the transmit word, 2 is command on write and status on read, and 3 is the received word.

Top module: `spi_word_master`

## Requirements
- R1: After reset, `csN` is 1, `sclk` is 0, status (address 2) reads 0, configuration (address 0) reads 0x00000007 (8-bit words, both clock bits 0, divider 0) and the received word (address 3) reads 0.
- R2: Configuration bits [4:0] hold the word length minus one, so lengths run from 4 to 32 bits. A written value of 0, 1 or 2 is stored and read back as 3, which gives a 4-bit word.
- R3: A transfer of length L sends bits L-1 down to 0 of the transmit word on `mosi`, in that order. The upper bits of the transmit word are not sent.
- R4: After a transfer, address 3 holds the L sampled `miso` bits. The first sampled bit sits at bit L-1 and the last at bit 0, and bits above L-1 read 0.
- R5: While no transfer runs, `sclk` rests at configuration bit 8 (the polarity bit).
- R6: Configuration bit 9 selects the phase. When it is 0, data is sampled on the leading (first, third, ...) `sclk` edges and changed on the trailing edges. When it is 1, data is changed on the leading edges and sampled on the trailing edges.
- R7: With divider N in configuration bits [31:16], each `sclk` half period lasts N+1 system clocks and a transfer makes exactly 2L `sclk` edges.
- R8: `csN` falls on the clock that accepts the start, one half period before the first `sclk` edge. It rises one half period after the last edge, so it stays low for (2L+1)(N+1) system clocks.
- R9: Writing address 2 with bit 0 set starts a transfer when the controller is idle. Status bit 0 is busy and status bit 1 is done. Done is set when `csN` rises and cleared by the next accepted start.
- R10: A start written while busy is ignored. The running transfer keeps its timing and its data.
- R11: Configuration writes made while busy are ignored, and the earlier configuration still reads back afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| csN | output | 1 | Active-low slave select |

## Verification
The assertions check on every cycle that a start while busy cannot restart or drop a transfer, and that the configuration is frozen during a transfer. They also check that done appears exactly when the select is released, that the edge count never passes 2L, that sample and shift strobes never coincide, and that `sclk` sits at the polarity level while idle. Only the bench's scenarios can show that the serial bit order, the phase choice, the received word alignment and the select low time are right for each mode and length. The bench shows this with a slave model that captures `mosi` and drives `miso`.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_TX  = 2'd1;
  localparam logic [1:0] ADDR_CMD = 2'd2;
  localparam logic [1:0] ADDR_RX  = 2'd3;

  localparam int CFG_POL_BIT = 8;
  localparam int CFG_PHA_BIT = 9;
  localparam int CFG_DIV_LSB = 16;

  typedef struct packed {
    logic load;    // latch transmit word, clear receive shifter
    logic toggle;  // flip sclk
    logic sample;  // capture miso
    logic shift;   // advance mosi
    logic finish;  // copy receive word out
  } spimStrobe_t;

endpackage

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       stb,
  input  logic              idle,
  input  logic              cpol,
  input  logic [LEN_W:0]    wordLen,
  input  logic [DATA_W-1:0] txWord,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData
);

  localparam logic [LEN_W:0] FULL_LEN = (LEN_W+1)'(DATA_W);

  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [LEN_W:0]    alignAmt;

  assign alignAmt = FULL_LEN - wordLen;
  assign mosi     = txShift[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
      sclk    <= 1'b0;
    end else begin
      if (stb.load) begin
        txShift <= txWord << alignAmt;
        rxShift <= '0;
      end else begin
        if (stb.shift)  txShift <= txShift << 1;
        if (stb.sample) rxShift <= {rxShift[DATA_W-2:0], miso};
      end
      if (stb.finish) rxData <= rxShift;
      if (stb.toggle)  sclk <= ~sclk;
      else if (idle)   sclk <= cpol;
    end
  end

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.sample && stb.shift));

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    idle && $past(idle) && $stable(cpol) |-> sclk == cpol);

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 16,
  parameter int MIN_LEN = 4,
  localparam int LEN_W  = $clog2(DATA_W),
  localparam int EDGE_W = LEN_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] rxData,
  output spimStrobe_t       stb,
  output logic              busy,
  output logic              cpol,
  output logic [LEN_W:0]    wordLen,
  output logic [DATA_W-1:0] txWord,
  output logic              csN
);

  localparam logic [LEN_W-1:0] MIN_M1 = LEN_W'(MIN_LEN - 1);
  localparam logic [LEN_W-1:0] RST_M1 = LEN_W'(7);

  logic [LEN_W-1:0]  cfgLen;
  logic              cpha;
  logic [DIV_W-1:0]  divVal;
  logic [DIV_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] totalEdges;
  logic              done;
  logic              startReq, accept, tick, allEdges, leading;
  logic [LEN_W-1:0]  lenIn;

  assign wordLen    = {1'b0, cfgLen} + 1'b1;
  assign totalEdges = {wordLen, 1'b0};
  assign startReq   = regWrEn && (regAddr == ADDR_CMD) && regWrData[0];
  assign accept     = startReq && !busy;
  assign tick       = busy && (divCnt == divVal);
  assign allEdges   = (edgeCnt == totalEdges);
  assign leading    = ~edgeCnt[0];
  assign lenIn      = regWrData[LEN_W-1:0];

  always_comb begin
    stb        = '0;
    stb.load   = accept;
    stb.toggle = tick && !allEdges;
    stb.sample = stb.toggle && (leading ^ cpha);
    stb.shift  = stb.toggle && !(leading ^ cpha) && !(cpha && edgeCnt == '0);
    stb.finish = tick && allEdges;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgLen  <= RST_M1;
      cpol    <= 1'b0;
      cpha    <= 1'b0;
      divVal  <= '0;
      txWord  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      csN     <= 1'b1;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else begin
      if (regWrEn && regAddr == ADDR_CFG && !busy) begin
        cfgLen <= (lenIn < MIN_M1) ? MIN_M1 : lenIn;
        cpol   <= regWrData[CFG_POL_BIT];
        cpha   <= regWrData[CFG_PHA_BIT];
        divVal <= regWrData[CFG_DIV_LSB +: DIV_W];
      end
      if (regWrEn && regAddr == ADDR_TX) txWord <= regWrData;
      if (accept) begin
        busy    <= 1'b1;
        done    <= 1'b0;
        csN     <= 1'b0;
        divCnt  <= '0;
        edgeCnt <= '0;
      end else if (busy) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (stb.toggle) edgeCnt <= edgeCnt + 1'b1;
        if (stb.finish) begin
          busy <= 1'b0;
          done <= 1'b1;
          csN  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CFG: begin
        regRdData[LEN_W-1:0]              = cfgLen;
        regRdData[CFG_POL_BIT]            = cpol;
        regRdData[CFG_PHA_BIT]            = cpha;
        regRdData[CFG_DIV_LSB +: DIV_W]   = divVal;
      end
      ADDR_TX:  regRdData = txWord;
      ADDR_CMD: regRdData[1:0] = {done, busy};
      default:  regRdData = rxData;
    endcase
  end

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && startReq && !stb.finish |=> busy && !done && edgeCnt >= $past(edgeCnt));

  p_done_cleared_r9: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy && !done && !csN);

  p_cs_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> done && !busy);

  p_edge_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> edgeCnt <= totalEdges);

  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy && !stb.finish |=> $stable(cfgLen) && $stable(cpol) && $stable(cpha) && $stable(divVal));

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spim_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 16,
  parameter int MIN_LEN = 4,
  localparam int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);

  spimStrobe_t       stb;
  logic              busy;
  logic              cpol;
  logic [LEN_W:0]    wordLen;
  logic [DATA_W-1:0] txWord;
  logic [DATA_W-1:0] rxData;

  spim_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .MIN_LEN(MIN_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .rxData(rxData),
    .stb(stb), .busy(busy), .cpol(cpol), .wordLen(wordLen),
    .txWord(txWord), .csN(csN)
  );

  spim_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .idle(!busy), .cpol(cpol),
    .wordLen(wordLen), .txWord(txWord), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rxData(rxData)
  );

endmodule

// File: tb/sim_spi_word_master.sv
module sim_spi_word_master;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  typedef struct packed {
    logic [4:0]  lenM1;
    logic        cpol;
    logic        cpha;
    logic [15:0] div;
    logic [31:0] tx;
    logic [31:0] sw;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{5'd7,  1'b0, 1'b0, 16'd0, 32'h0000_00A5, 32'h0000_003C},
    '{5'd7,  1'b0, 1'b1, 16'd1, 32'h0000_005A, 32'h0000_00C3},
    '{5'd3,  1'b1, 1'b0, 16'd2, 32'h0000_00F9, 32'h0000_0006},
    '{5'd31, 1'b1, 1'b1, 16'd0, 32'hDEAD_BEEF, 32'h1234_5678},
    '{5'd12, 1'b1, 1'b1, 16'd3, 32'hFFFF_1ABC, 32'h0000_0F0F},
    '{5'd1,  1'b0, 1'b0, 16'd0, 32'h0000_001D, 32'h0000_000B}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic sclk, mosi, csN;
  logic miso = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // slave model state
  logic        slvCpol = 0, slvCpha = 0;
  int          slvLen = 8;
  logic [31:0] slvOut = '0, slvIn = '0;
  int          bitIdx = 0, edgeCount = 0, lowCycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_word_master u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  always @(negedge csN) begin
    edgeCount = 0;
    slvIn = '0;
    bitIdx = slvLen - 1;
    if (!slvCpha) miso = slvOut[bitIdx];
  end

  always @(sclk) begin
    if (csN === 1'b0) begin
      edgeCount++;
      if ((sclk != slvCpol) ^ slvCpha) begin
        slvIn = {slvIn[30:0], mosi};
      end else if (slvCpha) begin
        if (bitIdx >= 0) miso = slvOut[bitIdx];
        bitIdx--;
      end else begin
        bitIdx--;
        if (bitIdx >= 0) miso = slvOut[bitIdx];
      end
    end
  end

  always @(negedge clk) if (csN === 1'b0) lowCycles++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [31:0] cfgWord(input vec_t v);
    return {v.div, 6'b0, v.cpha, v.cpol, 3'b0, v.lenM1};
  endfunction

  function automatic int effLen(input vec_t v);
    return (v.lenM1 < 5'd3) ? 4 : int'(v.lenM1) + 1;
  endfunction

  function automatic logic [31:0] lenMask(input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  task automatic runXfer(input vec_t v, input int id, input bit poke);
    logic [31:0] rd;
    logic [31:0] expCfg;
    int L, n;
    L = effLen(v);
    expCfg = cfgWord(v);
    expCfg[4:0] = 5'(L - 1);
    regWrite(2'd0, cfgWord(v));
    regWrite(2'd1, v.tx);
    slvCpol = v.cpol; slvCpha = v.cpha; slvLen = L; slvOut = v.sw;
    lowCycles = 0;
    regWrite(2'd2, 32'd1);
    regRead(2'd2, rd);
    chk($sformatf("R9 busy after start vec%0d", id), rd, 32'h1);
    if (poke) begin
      regWrite(2'd2, 32'd1);
      regWrite(2'd0, 32'h0005_0302);
    end
    n = 0;
    do begin regRead(2'd2, rd); n++; end while (!rd[1] && n < 20000);
    chk($sformatf("R9 done status vec%0d", id), rd, 32'h2);
    regRead(2'd3, rd);
    chk($sformatf("R4 R6 rx word vec%0d", id), rd, v.sw & lenMask(L));
    chk($sformatf("R3 R6 slave capture vec%0d", id), slvIn, v.tx & lenMask(L));
    chk($sformatf("R7 edge count vec%0d", id), edgeCount, 2 * L);
    chk($sformatf("R8 R7 cs low cycles vec%0d", id), lowCycles,
        (2 * L + 1) * (int'(v.div) + 1));
    chk($sformatf("R5 idle sclk vec%0d", id), {31'b0, sclk}, {31'b0, v.cpol});
    if (poke) begin
      regRead(2'd0, rd);
      chk("R11 config kept after busy write", rd, expCfg);
      chk("R10 start while busy ignored", lowCycles, (2 * L + 1) * (int'(v.div) + 1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    chk("R1 reset csN", {31'b0, csN}, 32'h1);
    chk("R1 reset sclk", {31'b0, sclk}, 32'h0);
    regRead(2'd2, rd); chk("R1 reset status", rd, 32'h0);
    regRead(2'd0, rd); chk("R1 reset config", rd, 32'h7);
    regRead(2'd3, rd); chk("R1 reset rx", rd, 32'h0);

    for (int i = 0; i < NV; i++) runXfer(VECS[i], i, 1'b0);

    // R2: length clamp and top of range
    regWrite(2'd0, 32'h0000_0000);
    regRead(2'd0, rd); chk("R2 length field 0 clamps to 3", rd, 32'h3);
    regWrite(2'd0, 32'h0000_0002);
    regRead(2'd0, rd); chk("R2 length field 2 clamps to 3", rd, 32'h3);
    regWrite(2'd0, 32'h0000_001F);
    regRead(2'd0, rd); chk("R2 length field 31 kept", rd, 32'h1F);

    // R5: idle level follows polarity
    regWrite(2'd0, 32'h0000_0107);
    @(negedge clk);
    chk("R5 idle sclk high", {31'b0, sclk}, 32'h1);
    regWrite(2'd0, 32'h0000_0007);
    @(negedge clk);
    chk("R5 idle sclk low", {31'b0, sclk}, 32'h0);

    // R10, R11: start and config writes while busy
    runXfer('{5'd7, 1'b0, 1'b0, 16'd3, 32'h0000_0096, 32'h0000_0069}, 90, 1'b1);

    // R9: done cleared by the next start
    regRead(2'd2, rd); chk("R9 done held while idle", rd, 32'h2);
    regWrite(2'd2, 32'd1);
    regRead(2'd2, rd); chk("R9 done cleared by start", rd, 32'h1);
    do regRead(2'd2, rd); while (!rd[1]);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule